// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is one bank of general-purpose I/O covering 32 pins. Each pin owns one bit in each of eight 32-bit registers. Those registers hold output data, the sampled input, output enable, interrupt routing, interrupt enable, trigger level select, trigger polarity and sticky interrupt status. Software reaches every register through a plain word-addressed register bus. Each register offers four access forms: plain write, bit-set, bit-clear and bit-toggle. A read at any of the four forms returns the register value.

Pad inputs are re-timed by a two-flop synchroniser before anything looks at them. Each pin's trigger type comes from two bits. The level bit chooses level (1) or edge (0) sensitivity. The polarity bit chooses high/rising (1) or low/falling (0). A detected trigger latches into the pin's status bit, but only when the pin's route bit is 1. The bank's single interrupt line is high whenever any status bit is set together with its enable bit.

The word address is `{index[2:0], form[1:0]}`; the byte offset of a word is four times its word address. The register index is: 0 output data, 1 input data, 2 output enable, 3 route, 4 enable, 5 level select, 6 polarity, 7 status. The form is: 0 write, 1 set, 2 clear, 3 toggle.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `pad_oe` is 0.
- R2: On a write, form 0 loads the data, form 1 ORs it in, form 2 clears the bits written as 1, and form 3 inverts the bits written as 1. A read at any form returns the current register value.
- R3: `pad_out` carries a pin's output-data bit only while that pin's output-enable bit (register 2) is 1, and is 0 otherwise. `pad_oe` equals register 2.
- R4: Register 1 returns the pad input two clock edges after the pad changes. Writes to register 1 have no effect.
- R5: With level=0 and polarity=1, a rising synchronised input sets the status bit once per transition. A pad held high does not set the bit again after a clear.
- R6: With level=0 and polarity=0, only a falling transition sets the status bit; a rising one does not.
- R7: With level=1, the status bit is set on every cycle that the input equals the polarity bit, so a clear does not remove it while that condition holds.
- R8: A status bit can become set only while the pin's route bit (register 3) is 1.
- R9: Status (register 7) changes through the clear form only. Writes at forms 0, 1 and 3 leave it unchanged.
- R10: `irq` is 1 exactly when the status AND enable (register 4) is non-zero.
- R11: A set-form write to the enable register also sets the same bits in the route register. Clear-form and other writes to the enable register leave route unchanged.
- R12: When a trigger and a software clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Word address {index, form} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output data, gated by output enable |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Bank interrupt |

## Verification
The risky overlap is a software clear of the status register landing in the same cycle that the detector sets that bit again. The bench provokes this by holding a level-high pin at its active level and then issuing a clear-form write to status. The bit must still read 1 after the write edge, and the pin must still assert the interrupt. The same clear is repeated after the pad has gone inactive, which separates set-wins behaviour from a clear that does not work at all.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_FLIP  = 2'd3
  } acc_form_e;

  localparam logic [2:0] IX_DOUT  = 3'd0;
  localparam logic [2:0] IX_DIN   = 3'd1;
  localparam logic [2:0] IX_OE    = 3'd2;
  localparam logic [2:0] IX_ROUTE = 3'd3;
  localparam logic [2:0] IX_IEN   = 3'd4;
  localparam logic [2:0] IX_LEVEL = 3'd5;
  localparam logic [2:0] IX_POL   = 3'd6;
  localparam logic [2:0] IX_STAT  = 3'd7;

  // Apply one access form to a stored word
  function automatic logic [31:0] apply_form(input logic [31:0] cur,
                                             input logic [1:0] form,
                                             input logic [31:0] data);
    case (form)
      ACC_WRITE: apply_form = data;
      ACC_SET:   apply_form = cur | data;
      ACC_CLEAR: apply_form = cur & ~data;
      default:   apply_form = cur ^ data;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] route,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] pol_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic edge_up, edge_dn, lvl_match, cond;
    always_comb begin
      edge_up   = cur[p] & ~prev_q[p];
      edge_dn   = ~cur[p] & prev_q[p];
      lvl_match = (cur[p] == pol_sel[p]);
      if (lvl_sel[p]) cond = lvl_match;
      else            cond = pol_sel[p] ? edge_up : edge_dn;
      hit[p] = route[p] & cond;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [2:0]   idx,
  input  logic [1:0]   form,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] din,
  input  logic [W-1:0] hit,
  output logic [W-1:0] rdata,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] route_q,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_clr;
  logic [W-1:0] nxt;

  assign nxt = W'(apply_form(32'(rdata), form, 32'(wdata)));
  assign stat_clr = (wr && idx == IX_STAT && form == ACC_CLEAR) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= '0;
      route_q <= '0;
      ien_q   <= '0;
      lvl_q   <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      case (idx)
        IX_DOUT:  dout_q  <= nxt;
        IX_OE:    oe_q    <= nxt;
        IX_ROUTE: route_q <= nxt;
        IX_IEN: begin
          ien_q <= nxt;
          if (form == ACC_SET) route_q <= route_q | wdata;
        end
        IX_LEVEL: lvl_q <= nxt;
        IX_POL:   pol_q <= nxt;
        default: ;
      endcase
    end
  end

  // Detector sets win over software clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | hit;
  end

  always_comb begin
    case (idx)
      IX_DOUT:  rdata = dout_q;
      IX_DIN:   rdata = din;
      IX_OE:    rdata = oe_q;
      IX_ROUTE: rdata = route_q;
      IX_IEN:   rdata = ien_q;
      IX_LEVEL: rdata = lvl_q;
      IX_POL:   rdata = pol_q;
      default:  rdata = stat_q;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam int FORM_W = 2;

  logic [NPIN-1:0] din_s, hit_vec;
  logic [NPIN-1:0] dout_q, oe_q, route_q, ien_q, lvl_q, pol_q, stat_q;
  logic [2:0]        reg_idx;
  logic [FORM_W-1:0] reg_form;

  assign reg_idx  = bus_addr[AW-1:FORM_W];
  assign reg_form = bus_addr[FORM_W-1:0];

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(din_s)
  );

  gpio_trig_detect #(.W(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(din_s), .route(route_q),
    .lvl_sel(lvl_q), .pol_sel(pol_q), .hit(hit_vec)
  );

  gpio_regfile #(.W(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .idx(reg_idx), .form(reg_form),
    .wdata(bus_wdata), .din(din_s), .hit(hit_vec), .rdata(bus_rdata),
    .dout_q(dout_q), .oe_q(oe_q), .route_q(route_q), .ien_q(ien_q),
    .lvl_q(lvl_q), .pol_q(pol_q), .stat_q(stat_q)
  );

  assign pad_oe  = oe_q;
  assign pad_out = dout_q & oe_q;
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic            irq,
  input logic [NPIN-1:0] stat_q,
  input logic [NPIN-1:0] ien_q,
  input logic [NPIN-1:0] route_q,
  input logic [NPIN-1:0] hit_vec
);
  logic            stat_wr_nonclr, ien_set_wr;
  logic [NPIN-1:0] clr_bits;

  assign stat_wr_nonclr = bus_wr && bus_addr[AW-1:2] == 3'd7 && bus_addr[1:0] != 2'd2;
  assign ien_set_wr     = bus_wr && bus_addr == {3'd4, 2'd1};
  assign clr_bits       = (bus_wr && bus_addr == {3'd7, 2'd2}) ? bus_wdata : '0;

  assert_gated_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  assert_route_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(route_q)) == '0);

  assert_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_nonclr |=> ($past(stat_q) & ~stat_q) == '0);

  assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ien_q) != '0) |-> irq);

  assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ien_q) == '0) |-> !irq);

  assert_route_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ien_set_wr |=> (route_q & $past(bus_wdata)) == $past(bus_wdata));

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & clr_bits) != '0) |=>
      (stat_q & $past(hit_vec & clr_bits)) == $past(hit_vec & clr_bits));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .stat_q(stat_q), .ien_q(ien_q), .route_q(route_q), .hit_vec(hit_vec)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic [31:0] pad_in = '0;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] DOUT = 0, DIN = 1, OE = 2, ROUTE = 3, IEN = 4, LVL = 5, POL = 6, STAT = 7;
  localparam logic [1:0] F_WR = 0, F_SET = 1, F_CLR = 2, F_TGL = 3;

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ix, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {ix, f}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] ix, input logic [1:0] f, input logic [31:0] exp);
    bus_addr = {ix, f};
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd("R1 dout", DOUT, F_WR, 0);
    rd("R1 route", ROUTE, F_WR, 0);
    rd("R1 ien", IEN, F_WR, 0);
    rd("R1 stat", STAT, F_WR, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 pad_oe", pad_oe, 0);
  endtask

  task automatic t_access;
    wr(DOUT, F_WR, 32'hA5A5_0F0F);  rd("R2 write", DOUT, F_WR, 32'hA5A5_0F0F);
    wr(DOUT, F_SET, 32'h0000_F000); rd("R2 set", DOUT, F_WR, 32'hA5A5_FF0F);
    wr(DOUT, F_CLR, 32'hA500_0000); rd("R2 clear", DOUT, F_WR, 32'h00A5_FF0F);
    wr(DOUT, F_TGL, 32'hFFFF_0000); rd("R2 toggle", DOUT, F_WR, 32'hFF5A_FF0F);
    rd("R2 read at clear form", DOUT, F_CLR, 32'hFF5A_FF0F);
    rd("R2 read at toggle form", DOUT, F_TGL, 32'hFF5A_FF0F);
  endtask

  task automatic t_pads;
    wr(OE, F_WR, 32'h0000_FFFF);
    check("R3 pad_out gated", pad_out, 32'h0000_FF0F);
    check("R3 pad_oe", pad_oe, 32'h0000_FFFF);
  endtask

  task automatic t_input;
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd("R4 one edge later", DIN, F_WR, 32'h0);
    @(negedge clk);
    rd("R4 two edges later", DIN, F_WR, 32'h1234_5678);
    wr(DIN, F_WR, 32'hFFFF_FFFF);
    rd("R4 write ignored", DIN, F_WR, 32'h1234_5678);
    pad_in = '0;
    cycles(4);
  endtask

  task automatic t_rise;
    wr(POL, F_SET, 32'h8);
    wr(IEN, F_SET, 32'h8);
    rd("R11 set enable sets route", ROUTE, F_WR, 32'h8);
    pad_in[3] = 1'b1;
    cycles(4);
    rd("R5 rising sets status", STAT, F_WR, 32'h8);
    check("R10 irq on", {31'd0, irq}, 1);
    wr(STAT, F_CLR, 32'h8);
    cycles(2);
    rd("R5 held high no reset", STAT, F_WR, 32'h0);
    check("R10 irq off", {31'd0, irq}, 0);
    pad_in[3] = 1'b0;
    cycles(4);
    rd("R5 falling ignored", STAT, F_WR, 32'h0);
  endtask

  task automatic t_fall;
    wr(IEN, F_SET, 32'h20);
    pad_in[5] = 1'b1;
    cycles(4);
    rd("R6 rising ignored", STAT, F_WR, 32'h0);
    pad_in[5] = 1'b0;
    cycles(4);
    rd("R6 falling sets", STAT, F_WR, 32'h20);
    wr(STAT, F_CLR, 32'h20);
    rd("R6 cleared", STAT, F_WR, 32'h0);
  endtask

  task automatic t_level;
    wr(LVL, F_SET, 32'h80);
    wr(POL, F_SET, 32'h80);
    wr(IEN, F_SET, 32'h80);
    pad_in[7] = 1'b1;
    cycles(4);
    rd("R7 high level sets", STAT, F_WR, 32'h80);
    wr(STAT, F_CLR, 32'h80);
    rd("R12 set beats clear", STAT, F_WR, 32'h80);
    check("R7 irq stays", {31'd0, irq}, 1);
    pad_in[7] = 1'b0;
    cycles(4);
    wr(STAT, F_CLR, 32'h80);
    rd("R7 clear after release", STAT, F_WR, 32'h0);
    wr(POL, F_CLR, 32'h80);
    cycles(1);
    rd("R7 low level sets", STAT, F_WR, 32'h80);
    pad_in[7] = 1'b1;
    cycles(4);
    wr(STAT, F_CLR, 32'h80);
    rd("R7 low level released", STAT, F_WR, 32'h0);
  endtask

  task automatic t_clear_only;
    pad_in[3] = 1'b1;
    cycles(4);
    rd("R5 second rising", STAT, F_WR, 32'h8);
    wr(STAT, F_WR, 32'h0);
    rd("R9 write form ignored", STAT, F_WR, 32'h8);
    wr(STAT, F_SET, 32'hFFFF_FFFF);
    rd("R9 set form ignored", STAT, F_WR, 32'h8);
    wr(STAT, F_TGL, 32'hFFFF_FFFF);
    rd("R9 toggle form ignored", STAT, F_WR, 32'h8);
    wr(IEN, F_CLR, 32'h8);
    check("R10 masked status no irq", {31'd0, irq}, 0);
    rd("R11 clear enable keeps route", ROUTE, F_WR, 32'hA8);
    wr(STAT, F_CLR, 32'h8);
    rd("R9 clear form clears", STAT, F_WR, 32'h0);
  endtask

  task automatic t_route_block;
    wr(POL, F_SET, 32'h200);
    wr(IEN, F_TGL, 32'h200);
    rd("R11 toggle enable leaves route", ROUTE, F_WR, 32'hA8);
    pad_in[9] = 1'b1;
    cycles(4);
    rd("R8 unrouted pin no status", STAT, F_WR, 32'h0);
    check("R8 irq low", {31'd0, irq}, 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_access();
    t_pads();
    t_input();
    t_rise();
    t_fall();
    t_level();
    t_clear_only();
    t_route_block();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule